// File: doc/BRIEF.md
# Configuration Index/Data Port Decoder

This block sits on the host I/O bus and turns a pair of 32-bit I/O ports into configuration transactions for the devices on the primary PCI bus. Software first writes a 32-bit selector to the index port. The selector carries an enable bit, a device number and a register offset. A later read or write at the data port then becomes a configuration read or write aimed at the selected device and register. If the enable bit is clear, or the device number has nothing behind it, the data-port access stays an ordinary I/O access.

The device number is decoded into a fixed one-hot select with one line per populated position: the host bridge, the ISA bridge, graphics, Ethernet, SCSI and three expansion slots. The block presents the request, the select, a dword-aligned register offset and the write data to the devices as registered outputs. For reads, it returns the selected device's data on the host side. Read data comes back with a fixed two-cycle latency and a valid pulse. Signalling on the PCI side is handled elsewhere.

Top module: `cfg_port_decoder`

## Requirements
- R1: A write at I/O address 0x0CF8 stores the 32-bit selector. A read at 0x0CF8 returns the stored value. The selector resets to 0x00000000.
- R2: A data-port access at 0x0CFC is a configuration access when the stored selector has bit 31 set and lists a present device. The block then raises `cfg_req` for exactly one cycle, on the cycle after the strobe. `cfg_we` is 1 for a write and 0 for a read.
- R3: The device number is selector bits 15:11. `cfg_dev_sel` bits 0..7 select devices 0, 2, 5, 6, 7, 13, 14 and 15 in that order, and exactly one bit is set while `cfg_req` is high.
- R4: `cfg_reg` equals selector bits 7:2 with its two low bits forced to 0.
- R5: During a configuration write, `cfg_wdata` carries the host write data of the triggering strobe.
- R6: With selector bit 31 clear, a data-port access raises no `cfg_req`, and a read returns 0xFFFFFFFF.
- R7: With bit 31 set but an unlisted device number, no `cfg_req` is raised. A read returns 0xFFFFFFFF and a write is dropped.
- R8: Every read at either port produces a one-cycle `io_rvalid` two clock edges after the strobe. For a configuration read, `io_rdata` is the value of `cfg_rdata` during the `cfg_req` cycle.
- R9: Strobes at any other I/O address change neither the selector nor the outputs, and they produce no `io_rvalid`.
- R10: While `cfg_req` is low, `cfg_dev_sel` is all zeros. A write strobe produces no `io_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 32 | Host write data |
| io_wr | input | 1 | Host write strobe, one cycle |
| io_rd | input | 1 | Host read strobe, one cycle |
| io_rdata | output | 32 | Host read data |
| io_rvalid | output | 1 | Read data valid pulse |
| cfg_req | output | 1 | Configuration request pulse |
| cfg_we | output | 1 | Configuration write (1) or read (0) |
| cfg_dev_sel | output | 8 | One-hot device select |
| cfg_reg | output | 8 | Dword-aligned register offset |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_rdata | input | 32 | Read data from the selected device |

## Verification
All 32 device numbers are swept with the enable bit both set and clear, and each combination is tried with a data-port write and a data-port read. This separates the eight present positions from the 24 absent ones, and it separates enabled accesses from plain I/O. Register offsets vary with nonzero low bits, and the function field is nonzero, so that masking of the offset and isolation of the device field both show up in the outputs. Stray addresses next to both ports confirm that only the exact port addresses decode. The bench's device model returns data built from the select and offset, so the read path is checked against the routed request.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  localparam int NUM_DEV = 8;
  localparam int DEV_W   = 5;
  localparam int DEV_LSB = 11;

  typedef enum logic [1:0] {
    RSP_NONE = 2'd0,
    RSP_IDX  = 2'd1,
    RSP_CFG  = 2'd2,
    RSP_ONES = 2'd3
  } rsp_kind_e;

  // device number wired to each select line, lowest line first
  function automatic logic [DEV_W-1:0] slot_devnum(input int line);
    case (line)
      0:       slot_devnum = 5'd0;
      1:       slot_devnum = 5'd2;
      2:       slot_devnum = 5'd5;
      3:       slot_devnum = 5'd6;
      4:       slot_devnum = 5'd7;
      5:       slot_devnum = 5'd13;
      6:       slot_devnum = 5'd14;
      default: slot_devnum = 5'd15;
    endcase
  endfunction

endpackage

// File: rtl/cfg_index_reg.sv
module cfg_index_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] idx_q
);

  always_ff @(posedge clk) begin
    if (rst)
      idx_q <= '0;
    else if (wr_en)
      idx_q <= wdata;
  end

endmodule

// File: rtl/cfg_dev_map.sv
module cfg_dev_map
  import cfg_port_pkg::*;
#(
  parameter int LINES = NUM_DEV
) (
  input  logic [DEV_W-1:0] devnum,
  output logic [LINES-1:0] sel,
  output logic             hit
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign sel[g] = (devnum == slot_devnum(g));
  end

  assign hit = |sel;

endmodule

// File: rtl/cfg_rsp.sv
module cfg_rsp
  import cfg_port_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  rsp_kind_e         kind,
  input  logic [DATA_W-1:0] idx_val,
  input  logic [DATA_W-1:0] dev_data,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= (kind != RSP_NONE);
      case (kind)
        RSP_IDX:  rdata <= idx_val;
        RSP_CFG:  rdata <= dev_data;
        RSP_ONES: rdata <= '1;
        default:  rdata <= rdata;
      endcase
    end
  end

endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
  import cfg_port_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              DATA_W    = 32,
  parameter int              REG_W     = 8,
  parameter logic [ADDR_W-1:0] IDX_PORT  = 16'h0CF8,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0CFC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_rvalid,
  output logic              cfg_req,
  output logic              cfg_we,
  output logic [NUM_DEV-1:0] cfg_dev_sel,
  output logic [REG_W-1:0]  cfg_reg,
  output logic [DATA_W-1:0] cfg_wdata,
  input  logic [DATA_W-1:0] cfg_rdata
);

  localparam int EN_BIT = DATA_W - 1;

  logic              idx_hit, dat_hit, dat_go;
  logic [DATA_W-1:0] idx_q;
  logic [NUM_DEV-1:0] map_sel;
  logic              map_hit;
  rsp_kind_e         s1_kind;
  logic [DATA_W-1:0] s1_idx;

  assign idx_hit = (io_addr == IDX_PORT);
  assign dat_hit = (io_addr == DATA_PORT);

  cfg_index_reg #(.DATA_W(DATA_W)) idx_i (
    .clk   (clk),
    .rst   (rst),
    .wr_en (io_wr & idx_hit),
    .wdata (io_wdata),
    .idx_q (idx_q)
  );

  cfg_dev_map #(.LINES(NUM_DEV)) map_i (
    .devnum (idx_q[DEV_LSB +: DEV_W]),
    .sel    (map_sel),
    .hit    (map_hit)
  );

  assign dat_go = dat_hit & (io_wr | io_rd) & idx_q[EN_BIT] & map_hit;

  // request stage toward the devices
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_req     <= 1'b0;
      cfg_we      <= 1'b0;
      cfg_dev_sel <= '0;
      cfg_reg     <= '0;
      cfg_wdata   <= '0;
    end else begin
      cfg_req     <= dat_go;
      cfg_we      <= dat_go & io_wr;
      cfg_dev_sel <= dat_go ? map_sel : '0;
      cfg_reg     <= dat_go ? {idx_q[REG_W-1:2], 2'b00} : '0;
      if (dat_go & io_wr)
        cfg_wdata <= io_wdata;
    end
  end

  // read bookkeeping aligned with the request stage
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_kind <= RSP_NONE;
      s1_idx  <= '0;
    end else begin
      s1_idx <= idx_q;
      if (io_wr || !io_rd)
        s1_kind <= RSP_NONE;
      else if (idx_hit)
        s1_kind <= RSP_IDX;
      else if (dat_hit)
        s1_kind <= dat_go ? RSP_CFG : RSP_ONES;
      else
        s1_kind <= RSP_NONE;
    end
  end

  cfg_rsp #(.DATA_W(DATA_W)) rsp_i (
    .clk      (clk),
    .rst      (rst),
    .kind     (s1_kind),
    .idx_val  (s1_idx),
    .dev_data (cfg_rdata),
    .rvalid   (io_rvalid),
    .rdata    (io_rdata)
  );

endmodule

// File: rtl/cfg_port_decoder_chk.sv
module cfg_port_decoder_chk #(
  parameter int              ADDR_W    = 16,
  parameter int              DATA_W    = 32,
  parameter int              REG_W     = 8,
  parameter int              LINES     = 8,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0CFC
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] io_addr,
  input logic [DATA_W-1:0] io_wdata,
  input logic              io_wr,
  input logic              io_rd,
  input logic              io_rvalid,
  input logic              cfg_req,
  input logic              cfg_we,
  input logic [LINES-1:0]  cfg_dev_sel,
  input logic [REG_W-1:0]  cfg_reg,
  input logic [DATA_W-1:0] cfg_wdata
);

  // R10
  sel_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_req |-> cfg_dev_sel == '0);

  // R3
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_req |-> $countones(cfg_dev_sel) == 1);

  // R4
  reg_align_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_req |-> cfg_reg[1:0] == 2'b00);

  // R2
  req_cause_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_req |-> $past(io_addr == DATA_PORT && (io_rd || io_wr)));

  // R2
  we_in_req_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |-> cfg_req);

  // R5
  wdata_follow_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_req && cfg_we |-> cfg_wdata == $past(io_wdata));

  // R8
  rvalid_cause_chk: assert property (@(posedge clk) disable iff (rst)
    io_rvalid |-> $past(io_rd && !io_wr, 2));

endmodule

bind cfg_port_decoder cfg_port_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W),
  .LINES(cfg_port_pkg::NUM_DEV), .DATA_PORT(DATA_PORT)
) chk_i (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
  .io_wr(io_wr), .io_rd(io_rd), .io_rvalid(io_rvalid),
  .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_dev_sel(cfg_dev_sel),
  .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata)
);

// File: tb/cfg_port_decoder_tb_top.sv
`timescale 1ns/1ps
module cfg_port_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic [31:0] io_wdata = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [31:0] io_rdata;
  logic        io_rvalid;
  logic        cfg_req, cfg_we;
  logic [7:0]  cfg_dev_sel;
  logic [7:0]  cfg_reg;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // device model: answers with its own select and register
  assign cfg_rdata = {cfg_dev_sel, 16'h0000, cfg_reg};

  cfg_port_decoder dut_i (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_dev_sel(cfg_dev_sel),
    .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  logic        s_req, s_we, s_rv;
  logic [7:0]  s_sel, s_reg;
  logic [31:0] s_wd, s_rd;

  function automatic logic [7:0] exp_sel(input int dn);
    case (dn)
      0:  return 8'h01;
      2:  return 8'h02;
      5:  return 8'h04;
      6:  return 8'h08;
      7:  return 8'h10;
      13: return 8'h20;
      14: return 8'h40;
      15: return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the response slot
  task automatic bus_op(input logic [15:0] a, input logic [31:0] d,
                        input bit w, input bit r);
    io_addr = a; io_wdata = d; io_wr = w; io_rd = r;
    @(negedge clk);
    s_req = cfg_req; s_we = cfg_we; s_sel = cfg_dev_sel;
    s_reg = cfg_reg; s_wd = cfg_wdata;
    io_wr = 0; io_rd = 0;
    @(negedge clk);
    s_rv = io_rvalid; s_rd = io_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state
    chk(cfg_req == 0, "R2", "reset cfg_req", 32'(cfg_req), 0);
    chk(cfg_dev_sel == 0, "R10", "reset sel", 32'(cfg_dev_sel), 0);
    chk(io_rvalid == 0, "R8", "reset rvalid", 32'(io_rvalid), 0);
    bus_op(16'h0CF8, 0, 0, 1);
    chk(s_rv == 1, "R1", "reset index rvalid", 32'(s_rv), 1);
    chk(s_rd == 0, "R1", "reset index value", s_rd, 0);

    for (int en = 0; en < 2; en++) begin
      for (int dn = 0; dn < 32; dn++) begin
        logic [7:0]  off = 8'((dn * 37 + en * 11 + 3) & 255);
        logic [31:0] idx = (32'(en) << 31) | (32'(dn + 1) << 16) |
                           (32'(dn) << 11) | (32'(dn % 8) << 8) | 32'(off);
        logic [7:0]  es = exp_sel(dn);
        bit          go = (en == 1) && (es != 0);
        logic [31:0] wd = 32'hA5000000 ^ (32'(dn) << 8) ^ 32'(en);
        logic [31:0] er = go ? {es, 16'h0000, off & 8'hFC} : 32'hFFFFFFFF;

        bus_op(16'h0CF8, idx, 1, 0);
        chk(s_req == 0, "R1", "index write no req", 32'(s_req), 0);
        chk(s_rv == 0, "R10", "index write no rvalid", 32'(s_rv), 0);
        bus_op(16'h0CF8, 0, 0, 1);
        chk(s_rv == 1 && s_rd == idx, "R1", "index readback", s_rd, idx);

        // data write
        bus_op(16'h0CFC, wd, 1, 0);
        chk(s_req == go, go ? "R2" : (en == 0 ? "R6" : "R7"), "write req",
            32'(s_req), 32'(go));
        if (go) begin
          chk(s_we == 1, "R2", "write we", 32'(s_we), 1);
          chk(s_sel == es, "R3", "write sel", 32'(s_sel), 32'(es));
          chk(s_reg == (off & 8'hFC), "R4", "write reg", 32'(s_reg), 32'(off & 8'hFC));
          chk(s_wd == wd, "R5", "write data", s_wd, wd);
        end else begin
          chk(s_sel == 0, "R10", "idle sel", 32'(s_sel), 0);
        end
        chk(s_rv == 0, "R10", "data write no rvalid", 32'(s_rv), 0);

        // data read
        bus_op(16'h0CFC, 0, 0, 1);
        chk(s_req == go, go ? "R2" : (en == 0 ? "R6" : "R7"), "read req",
            32'(s_req), 32'(go));
        if (go) begin
          chk(s_we == 0, "R2", "read we", 32'(s_we), 0);
          chk(s_sel == es, "R3", "read sel", 32'(s_sel), 32'(es));
        end
        chk(s_rv == 1, "R8", "read rvalid", 32'(s_rv), 1);
        chk(s_rd == er, go ? "R8" : (en == 0 ? "R6" : "R7"), "read data", s_rd, er);
      end
    end

    // stray addresses next to both ports
    bus_op(16'h0CF8, 32'h80001004, 1, 0);
    bus_op(16'h0CF9, 32'h12345678, 1, 0);
    chk(s_req == 0 && s_rv == 0, "R9", "stray write idle", 32'({s_req, s_rv}), 0);
    bus_op(16'h0CFD, 32'h12345678, 1, 0);
    chk(s_req == 0, "R9", "stray write near data", 32'(s_req), 0);
    bus_op(16'h0CF4, 0, 0, 1);
    chk(s_req == 0 && s_rv == 0, "R9", "stray read", 32'({s_req, s_rv}), 0);
    bus_op(16'h0CFE, 0, 0, 1);
    chk(s_req == 0 && s_rv == 0, "R9", "stray read near data", 32'({s_req, s_rv}), 0);
    bus_op(16'h0CF8, 0, 0, 1);
    chk(s_rd == 32'h80001004, "R9", "index unchanged", s_rd, 32'h80001004);
    bus_op(16'h0CFC, 0, 0, 1);
    chk(s_req == 1 && s_sel == 8'h02 && s_reg == 8'h04, "R3", "after stray",
        {s_sel, s_reg, 15'h0, s_req}, {8'h02, 8'h04, 15'h0, 1'b1});

    // reset clears the selector
    rst = 1; @(negedge clk); rst = 0; @(negedge clk);
    bus_op(16'h0CF8, 0, 0, 1);
    chk(s_rd == 0, "R1", "index after reset", s_rd, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule